// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter units. Each unit has a low and a high count byte, a run bit and a sticky overflow flag. A shared mode byte gives each unit four configuration bits: a gate qualifier, a source select and a two-bit structure select. A unit advances on one of two sources. The first is an internal tick that fires once every `PRESCALE` clocks. The second is a falling edge on that unit's count pin.

The structure select turns each unit into one of four counters:
- a 13-bit counter, in which five low bits act as a prescaler below an 8-bit high byte;
- a full 16-bit counter;
- an 8-bit counter that reloads from the high byte whenever it wraps;
- a split arrangement, in which timer 0 becomes two independent 8-bit counters and timer 1 holds still.

Software loads and reads the count bytes, the mode byte and the run/flag bits through a simple byte-wide register port. Each overflow also drives a one-clock pulse per unit. A neighbouring serial block can use that pulse as a rate tick, and an interrupt controller can watch the flags.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0, and `ovf_flag` and `ovf_pulse` are 0.
- R2: Structure 00 (13-bit) counts in low-byte bits [4:0]. The carry out of 0x1F increments the high byte. The step from high 0xFF with low bits 0x1F wraps both to 0 and sets the flag. Low-byte bits [7:5] keep their value.
- R3: Structure 01 (16-bit) counts {high, low} upward. The step from 0xFFFF wraps to 0x0000 and sets the flag.
- R4: Structure 10 (8-bit reload) counts the low byte. On the step from 0xFF, the low byte takes the high byte's value, the high byte is unchanged, and the flag is set.
- R5: Structure 11 on timer 0 splits it into two 8-bit counters:
  - The low byte uses timer 0's source, run bit and gate, and its wrap sets flag 0.
  - The high byte counts internal ticks while run bit 1 is set, and its wrap sets flag 1.
  - While timer 0 is split, timer 1's own wraps do not set flag 1.
  - Timer 1 set to structure 11 holds its count.
- R6: With the gate bit 1, a unit counts only while its synchronized gate pin is high. With the gate bit 0, the gate pin has no effect.
- R7: Source select 0 counts the internal tick, which occurs once every `PRESCALE` (default 12) clocks. Source select 1 counts only falling edges on the count pin, and the internal tick alone then does not advance the unit.
- R8: With its run bit 0, a unit's count bytes do not change except by register writes.
- R9: A flag set by an overflow stays set until software writes 0 to it through the control register. A hardware set in the same cycle wins over that write. Each overflow gives a pulse on `ovf_pulse` that lasts one clock.
- R10: Register map (`reg_addr`):
  - 0: mode byte. Bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble, bit 3 is gate, bit 2 is source select and bits 1:0 are the structure.
  - 1: control. Bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1.
  - 2: timer 0 low byte. 3: timer 0 high byte. 4: timer 1 low byte. 5: timer 1 high byte.
  - Each write lands on the next clock, and reads are combinational.
- R11: Count pins pass through a two-stage synchronizer. Falling edges seen within one internal tick window add at most one count, applied at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cnt_pin | input | 2 | External count pins, one per unit (falling edge counts) |
| gate_pin | input | 2 | Gate qualifier pins, one per unit |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_pulse | output | 2 | One-clock overflow pulses, per unit |

## Verification
The properties assume that `PRESCALE` is at least 2, so that two count events can never fall on adjacent clocks. They also assume that software changes a count byte only through a write strobe and never in the same cycle as a control write it depends on. The stimulus spaces count-pin edges much wider than one tick window, so each edge counts exactly once; the single exception is the deliberate burst for R11, which is aligned to a known tick using the timer 1 pulse. Gate and count pins change only on the falling clock edge, and the checks read results only after the synchronizer and the next tick have settled.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_TMR  = 2;
  localparam int PRE_BITS = 5;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_cfg_t;

  typedef struct packed {
    logic              wrap;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } tmr_step_t;

  // plain 8-bit increment with carry out in the top bit
  function automatic logic [BYTE_W:0] inc_byte(logic [BYTE_W-1:0] v);
    return {1'b0, v} + 1'b1;
  endfunction

  // one count step of a unit in the given structure
  function automatic tmr_step_t step_count(tmr_mode_e m,
                                           logic [BYTE_W-1:0] hi,
                                           logic [BYTE_W-1:0] lo);
    tmr_step_t           r;
    logic [PRE_BITS:0]   pre;
    logic [BYTE_W:0]     wide;
    logic [2*BYTE_W:0]   w16;
    r.wrap = 1'b0;
    r.hi   = hi;
    r.lo   = lo;
    pre    = '0;
    wide   = '0;
    w16    = '0;
    case (m)
      MODE_13: begin
        pre = {1'b0, lo[PRE_BITS-1:0]} + 1'b1;
        r.lo[PRE_BITS-1:0] = pre[PRE_BITS-1:0];
        if (pre[PRE_BITS]) begin
          wide   = inc_byte(hi);
          r.hi   = wide[BYTE_W-1:0];
          r.wrap = wide[BYTE_W];
        end
      end
      MODE_16: begin
        w16    = {1'b0, hi, lo} + 1'b1;
        r.hi   = w16[2*BYTE_W-1:BYTE_W];
        r.lo   = w16[BYTE_W-1:0];
        r.wrap = w16[2*BYTE_W];
      end
      MODE_RELOAD: begin
        if (lo == '1) begin
          r.lo   = hi;
          r.wrap = 1'b1;
        end else begin
          wide = inc_byte(lo);
          r.lo = wide[BYTE_W-1:0];
        end
      end
      default: begin
        wide   = inc_byte(lo);
        r.lo   = wide[BYTE_W-1:0];
        r.wrap = wide[BYTE_W];
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_s,
  input  logic ext_src,
  output logic evt,
  output logic fall
);
  logic prev;
  logic pend;

  assign fall = prev & ~pin_s;
  assign evt  = ext_src ? (tick & (pend | fall)) : tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= pin_s;
      if (tick)      pend <= 1'b0;
      else if (fall) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pair_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              cnt_en,
  input  logic              hi_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap_main,
  output logic              wrap_hi
);
  tmr_step_t       step;
  logic [BYTE_W:0] hi_inc;
  logic            split_mode;
  logic            main_go;

  assign split_mode = (mode == MODE_SPLIT);
  assign main_go    = cnt_en && (SPLIT_OK || !split_mode);
  assign hi_inc     = inc_byte(hi);

  always_comb step = step_count(mode, hi, lo);

  assign wrap_main = main_go && step.wrap;
  assign wrap_hi   = SPLIT_OK && split_mode && hi_en && hi_inc[BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)        lo <= wdata;
      else if (main_go) lo <= step.lo;

      if (wr_hi) hi <= wdata;
      else if (SPLIT_OK && split_mode) begin
        if (hi_en) hi <= hi_inc[BYTE_W-1:0];
      end else if (main_go) hi <= step.hi;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [NUM_TMR-1:0] cnt_pin,
  input  logic [NUM_TMR-1:0] gate_pin,
  output logic [NUM_TMR-1:0] ovf_flag,
  output logic [NUM_TMR-1:0] ovf_pulse
);
  localparam int CFG_W = $bits(tmr_cfg_t);

  logic                          tick;
  logic [2*NUM_TMR-1:0]          pins_s;
  logic [NUM_TMR-1:0]            cnt_s;
  logic [NUM_TMR-1:0]            gate_s;
  logic [NUM_TMR*CFG_W-1:0]      cfg_q;
  logic [NUM_TMR-1:0]            run_q;
  logic [NUM_TMR-1:0]            flag_q;
  logic [NUM_TMR-1:0]            pulse_q;
  logic [NUM_TMR-1:0][BYTE_W-1:0] cnt_lo;
  logic [NUM_TMR-1:0][BYTE_W-1:0] cnt_hi;
  logic [NUM_TMR-1:0]            evt;
  logic [NUM_TMR-1:0]            edge_seen;
  logic [NUM_TMR-1:0]            gate_ok;
  logic [NUM_TMR-1:0]            cnt_en;
  logic [NUM_TMR-1:0]            hi_en;
  logic [NUM_TMR-1:0]            ovf_main;
  logic [NUM_TMR-1:0]            ovf_hi;
  logic [NUM_TMR-1:0]            flag_set;
  logic                          ctrl_wr;
  logic                          split0;
  tmr_cfg_t                      cfg [NUM_TMR];

  tmr_tick_gen #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tmr_sync #(.W(2*NUM_TMR), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({gate_pin, cnt_pin}), .dout(pins_s)
  );

  assign cnt_s  = pins_s[NUM_TMR-1:0];
  assign gate_s = pins_s[2*NUM_TMR-1:NUM_TMR];
  assign split0 = (cfg[0].mode == MODE_SPLIT);
  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

  genvar i;
  generate
    for (i = 0; i < NUM_TMR; i++) begin : g_tmr
      localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 + 2*i);
      localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(3 + 2*i);

      assign cfg[i]     = tmr_cfg_t'(cfg_q[i*CFG_W +: CFG_W]);
      assign gate_ok[i] = ~cfg[i].gate | gate_s[i];
      assign cnt_en[i]  = run_q[i] & gate_ok[i] & evt[i];

      if (i == 0) begin : g_hi_src
        assign hi_en[i] = split0 & run_q[1] & tick;
      end else begin : g_hi_off
        assign hi_en[i] = 1'b0;
      end

      tmr_event u_evt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin_s(cnt_s[i]),
        .ext_src(cfg[i].ext_src), .evt(evt[i]), .fall(edge_seen[i])
      );

      tmr_unit #(.SPLIT_OK(i == 0)) u_unit (
        .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
        .cnt_en(cnt_en[i]), .hi_en(hi_en[i]),
        .wr_lo(reg_we && (reg_addr == LO_ADDR)),
        .wr_hi(reg_we && (reg_addr == HI_ADDR)),
        .wdata(reg_wdata), .lo(cnt_lo[i]), .hi(cnt_hi[i]),
        .wrap_main(ovf_main[i]), .wrap_hi(ovf_hi[i])
      );
    end
  endgenerate

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split0 ? ovf_hi[0] : ovf_main[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      run_q   <= '0;
      flag_q  <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= ovf_main;
      if (reg_we && (reg_addr == A_MODE)) cfg_q <= reg_wdata;
      if (ctrl_wr) begin
        run_q  <= reg_wdata[NUM_TMR-1:0];
        flag_q <= reg_wdata[2*NUM_TMR-1:NUM_TMR] | flag_set;
      end else begin
        flag_q <= flag_q | flag_set;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = cfg_q;
      A_CTRL:  reg_rdata = {{(BYTE_W-2*NUM_TMR){1'b0}}, flag_q, run_q};
      A_LO0:   reg_rdata = cnt_lo[0];
      A_HI0:   reg_rdata = cnt_hi[0];
      A_LO1:   reg_rdata = cnt_lo[1];
      A_HI1:   reg_rdata = cnt_hi[1];
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag  = flag_q;
  assign ovf_pulse = pulse_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pair_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [2*NUM_TMR*2-1:0]        cfg_q,
  input logic [NUM_TMR-1:0]            run_q,
  input logic [NUM_TMR-1:0]            flag_q,
  input logic [NUM_TMR-1:0]            pulse_q,
  input logic [NUM_TMR-1:0][BYTE_W-1:0] cnt_lo,
  input logic [NUM_TMR-1:0][BYTE_W-1:0] cnt_hi,
  input logic [NUM_TMR-1:0]            ovf_main
);
  logic ctrl_wr, lo0_wr, hi0_wr, lo1_wr, hi1_wr;
  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
  assign lo0_wr  = reg_we && (reg_addr == A_LO0);
  assign hi0_wr  = reg_we && (reg_addr == A_HI0);
  assign lo1_wr  = reg_we && (reg_addr == A_LO1);
  assign hi1_wr  = reg_we && (reg_addr == A_HI1);

  // R9
  flag0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !ctrl_wr) |=> flag_q[0]);

  // R9
  flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !ctrl_wr) |=> flag_q[1]);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[0] |-> flag_q[0]);

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[0] |=> !pulse_q[0]);

  // R8
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !lo0_wr) |=> $stable(cnt_lo[0]));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b10 && ovf_main[0] && !lo0_wr) |=> (cnt_lo[0] == $past(cnt_hi[0])));

  // R2
  mode13_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b00 && !lo0_wr) |=> $stable(cnt_lo[0][7:5]));

  // R5
  t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b11 && !lo1_wr && !hi1_wr) |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));

  // R3
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b01 && ovf_main[0] && !lo0_wr && !hi0_wr) |=> (cnt_lo[0] == 8'h00 && cnt_hi[0] == 8'h00));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cfg_q(cfg_q), .run_q(run_q), .flag_q(flag_q), .pulse_q(pulse_q),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_main(ovf_main)
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b11;
  logic [1:0] ovf_flag;
  logic [1:0] ovf_pulse;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  typedef struct packed {
    logic [3:0] cfg;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [3:0] edges;
    logic [7:0] exp_hi;
    logic [7:0] exp_lo;
    logic       exp_flag;
    logic [3:0] req;
  } vec_t;

  // timer 0 nibble: gate=0, source=external, structure in [1:0]
  localparam vec_t VECS [10] = '{
    '{4'b0100, 8'h00, 8'h00, 4'd3, 8'h00, 8'h03, 1'b0, 4'd2},  // R2
    '{4'b0100, 8'h05, 8'h1F, 4'd1, 8'h06, 8'h00, 1'b0, 4'd2},  // R2 carry
    '{4'b0100, 8'hFF, 8'h1E, 4'd2, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 wrap
    '{4'b0100, 8'h12, 8'hE0, 4'd2, 8'h12, 8'hE2, 1'b0, 4'd2},  // R2 upper bits held
    '{4'b0100, 8'hFF, 8'hFF, 4'd1, 8'h00, 8'hE0, 1'b1, 4'd2},  // R2 wrap, upper held
    '{4'b0101, 8'h00, 8'hFE, 4'd3, 8'h01, 8'h01, 1'b0, 4'd3},  // R3
    '{4'b0101, 8'hFF, 8'hFF, 4'd1, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 wrap
    '{4'b0110, 8'h80, 8'hFE, 4'd3, 8'h80, 8'h81, 1'b1, 4'd4},  // R4 reload
    '{4'b0110, 8'h00, 8'h10, 4'd2, 8'h00, 8'h12, 1'b0, 4'd4},  // R4
    '{4'b0111, 8'h33, 8'hFF, 4'd1, 8'h33, 8'h00, 1'b1, 4'd5}   // R5 low half
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pin_edge(input int ch);
    @(negedge clk);
    cnt_pin[ch] = 1'b0;
    repeat (14) @(negedge clk);
    cnt_pin[ch] = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      reg_read(3'(a), d);
      check("R1 register reset", d, 0);
    end
    check("R1 flag reset", ovf_flag, 0);
    check("R1 pulse reset", ovf_pulse, 0);

    // table of structure vectors (R2 R3 R4 R5)
    for (int v = 0; v < 10; v++) begin
      reg_write(3'd1, 8'h00);
      reg_write(3'd0, {4'b0000, VECS[v].cfg});
      reg_write(3'd2, VECS[v].lo);
      reg_write(3'd3, VECS[v].hi);
      reg_write(3'd1, 8'h01);
      for (int e = 0; e < int'(VECS[v].edges); e++) pin_edge(0);
      repeat (20) @(negedge clk);
      reg_read(3'd3, d);
      check($sformatf("R%0d vec %0d high", VECS[v].req, v), d, VECS[v].exp_hi);
      reg_read(3'd2, d);
      check($sformatf("R%0d vec %0d low", VECS[v].req, v), d, VECS[v].exp_lo);
      reg_read(3'd1, d);
      check($sformatf("R%0d vec %0d flag", VECS[v].req, v), d[2], VECS[v].exp_flag);
    end

    // R7 internal tick period, R9 pulse width
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h02);
    reg_write(3'd2, 8'hFF);
    reg_write(3'd3, 8'hFF);
    reg_write(3'd1, 8'h01);
    n = 0;
    while (!ovf_pulse[0] && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    check("R9 pulse one clock", ovf_pulse[0], 0);
    n = 1;
    while (!ovf_pulse[0] && n < 100) begin @(negedge clk); n++; end
    check("R7 tick period", n, 12);
    check("R9 flag set by overflow", ovf_flag[0], 1);

    // R7 external source ignores internal tick
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h05);
    reg_write(3'd2, 8'h00);
    reg_write(3'd3, 8'h00);
    reg_write(3'd1, 8'h01);
    repeat (60) @(negedge clk);
    reg_read(3'd2, d);
    check("R7 no count without edges", d, 0);
    pin_edge(0);
    repeat (5) @(negedge clk);
    reg_read(3'd2, d);
    check("R7 edge counts", d, 1);

    // R8 run off
    reg_write(3'd1, 8'h00);
    pin_edge(0);
    pin_edge(0);
    reg_read(3'd2, d);
    check("R8 run off holds", d, 1);

    // R6 gate
    reg_write(3'd0, 8'h0D);
    reg_write(3'd2, 8'h00);
    reg_write(3'd1, 8'h01);
    gate_pin[0] = 1'b0;
    repeat (5) @(negedge clk);
    pin_edge(0);
    pin_edge(0);
    reg_read(3'd2, d);
    check("R6 gate low blocks", d, 0);
    gate_pin[0] = 1'b1;
    repeat (5) @(negedge clk);
    pin_edge(0);
    pin_edge(0);
    reg_read(3'd2, d);
    check("R6 gate high counts", d, 2);

    // R9 sticky flag and software clear
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h05);
    reg_write(3'd2, 8'hFF);
    reg_write(3'd3, 8'hFF);
    reg_write(3'd1, 8'h01);
    pin_edge(0);
    repeat (50) @(negedge clk);
    reg_read(3'd1, d);
    check("R9 flag sticky", d[2], 1);
    check("R9 flag port", ovf_flag[0], 1);
    reg_write(3'd1, 8'h01);
    reg_read(3'd1, d);
    check("R9 flag cleared by write", d, 8'h01);

    // R5 split: high half on internal ticks via run 1
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h17);
    reg_write(3'd2, 8'h44);
    reg_write(3'd3, 8'h00);
    reg_write(3'd4, 8'hFE);
    reg_write(3'd5, 8'hFF);
    reg_write(3'd1, 8'h02);
    repeat (30) @(negedge clk);
    reg_read(3'd3, d);
    check("R5 high half ticks", (d == 8'h02 || d == 8'h03) ? 1 : 0, 1);
    reg_read(3'd2, d);
    check("R5 low half idle", d, 8'h44);
    reg_read(3'd1, d);
    check("R5 timer1 wrap no flag", d[3], 0);
    reg_write(3'd3, 8'hFF);
    repeat (15) @(negedge clk);
    reg_read(3'd1, d);
    check("R5 high half sets flag1", d[3], 1);
    reg_write(3'd0, 8'h37);
    reg_write(3'd4, 8'h55);
    repeat (40) @(negedge clk);
    reg_read(3'd4, d);
    check("R5 timer1 holds", d, 8'h55);

    // R11 burst of edges in one tick window
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h25);
    reg_write(3'd4, 8'hFF);
    reg_write(3'd5, 8'hFF);
    reg_write(3'd2, 8'h00);
    reg_write(3'd3, 8'h00);
    reg_write(3'd1, 8'h03);
    n = 0;
    while (!ovf_pulse[1] && n < 100) begin @(negedge clk); n++; end
    cnt_pin[0] = 1'b0;
    @(negedge clk);
    cnt_pin[0] = 1'b1;
    @(negedge clk);
    cnt_pin[0] = 1'b0;
    @(negedge clk);
    cnt_pin[0] = 1'b1;
    repeat (30) @(negedge clk);
    reg_read(3'd2, d);
    check("R11 one count per window", d, 1);

    // R10 read back
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h9C);
    reg_read(3'd0, d);
    check("R10 mode readback", d, 8'h9C);
    reg_write(3'd5, 8'hA5);
    reg_read(3'd5, d);
    check("R10 timer1 high readback", d, 8'hA5);

    summary();
    $finish;
  end
endmodule